// File: doc/BRIEF.md
# Video Timing Generator

This block turns a programmed raster geometry into the timing strobes a display pipeline needs. The strobes are horizontal and vertical sync, horizontal and vertical blank, active video, active chroma and a field indicator. Two counters run over the frame. The pixel counter runs over the line, and the line counter runs over the frame. Every strobe is decoded from these two counters. Vertical sync and vertical blank start and stop at a programmed cycle inside a line, not at a line boundary. Each strobe has its own polarity. The chroma strobe can follow a 4:2:0 pattern that is gated by line parity and, optionally, by pixel parity.

All configuration arrives as shadow values on the `cfg_*` inputs. The generator runs from a working copy of these values. The working copy is refreshed only at the frame wrap, or while the generator is stopped, and only while `upd_req_i` is high. A mid-frame change therefore never tears a frame. The block also produces three single-cycle signals: a frame-sync pulse at a programmed line and cycle, and one event each for the first cycle of active video and of vertical blank, which are meant for an interrupt controller.

Top module: `video_timing_gen`

## Requirements
- R1: The pixel count runs from 0 to `htotal-1`, and the line count advances on each wrap. Horizontal sync is active for pixel counts greater than or equal to `hs_beg` and less than `hs_fin`.
- R2: Vertical sync becomes active at line `vs_beg_line`, pixel `vs_beg_cyc`. It becomes inactive at line `vs_fin_line`, pixel `vs_fin_cyc`, and that cycle itself is already inactive.
- R3: Vertical blank becomes active at line `vactive`, pixel `vb_beg_cyc`. It becomes inactive at line 0, pixel `vb_fin_cyc`, of the following frame. The first frame after a start carries no blank on line 0.
- R4: Active video is high when the pixel count is below `hactive` and the line count is below `vactive`. Horizontal blank is high when the pixel count is `hactive` or greater.
- R5: `cfg_pol` bits are assigned as follows: 0 hsync, 1 vsync, 2 hblank, 3 vblank, 4 video, 5 chroma, 6 field. For bits 0 to 5, a 1 makes the strobe active-high and a 0 makes it active-low. The design is progressive, so it is always in field 0, and the field output equals bit 6.
- R6: `cfg_fmt` selects the format: 0 for 4:2:2, 1 for 4:4:4, 2 for RGB and 3 for 4:2:0. Formats 0 to 2 drive chroma equal to active video. In format 3, chroma is active only on active lines whose line-count LSB equals `cpar[0]`. When `cpar[1]` is 1, chroma is further limited to even pixel counts.
- R7: Working values are copied from the `cfg_*` inputs only at the edge where the last pixel of the last line wraps to 0, or while the generator is stopped, and in both cases only while `upd_req_i` is 1.
- R8: `ev_video_o` pulses for exactly the first cycle of each active-video run. `ev_vblank_o` pulses for the first cycle of vertical blank.
- R9: `fsync_o` is high, active-high, for the single cycle at line `fs_line`, pixel `fs_cyc`.
- R10: The generator runs while `glb_en_i` OR `gen_en_i` is high. When stopped, both counters hold 0, every strobe sits at its inactive level, and `fsync_o` and both events stay low.
- R11: A one-cycle `soft_rst_i` pulse raises `rst_busy_o` for one cycle. During that cycle the outputs are inactive. After it, `rst_busy_o` clears by itself and the frame restarts from line 0, pixel 0.
- R12: After `rst_ni`, the working polarity is 0: strobes 0 to 5 read 1, the field output reads 0, and the pulses and `rst_busy_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global enable |
| gen_en_i | input | 1 | Generator-only enable |
| soft_rst_i | input | 1 | Write-one soft reset pulse |
| upd_req_i | input | 1 | Allow shadow-to-working copy |
| cfg_htotal_i | input | W | Pixels per line including blank |
| cfg_hactive_i | input | W | Active pixels per line |
| cfg_vtotal_i | input | W | Lines per frame including blank |
| cfg_vactive_i | input | W | Active lines per frame |
| cfg_hs_beg_i | input | W | First pixel of hsync |
| cfg_hs_fin_i | input | W | First pixel after hsync |
| cfg_vs_beg_line_i | input | W | Line where vsync starts |
| cfg_vs_beg_cyc_i | input | W | Pixel where vsync starts |
| cfg_vs_fin_line_i | input | W | Line where vsync ends |
| cfg_vs_fin_cyc_i | input | W | Pixel where vsync ends |
| cfg_vb_beg_cyc_i | input | W | Pixel where vblank starts |
| cfg_vb_fin_cyc_i | input | W | Pixel where vblank ends |
| cfg_fs_line_i | input | W | Frame-sync line |
| cfg_fs_cyc_i | input | W | Frame-sync pixel |
| cfg_pol_i | input | 7 | Polarity bits (see R5) |
| cfg_fmt_i | input | 2 | Video format code |
| cfg_cpar_i | input | 2 | 4:2:0 chroma parity mode |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| video_o | output | 1 | Active video |
| chroma_o | output | 1 | Active chroma |
| field_o | output | 1 | Field indicator |
| fsync_o | output | 1 | Frame-sync pulse |
| ev_video_o | output | 1 | First-cycle active video event |
| ev_vblank_o | output | 1 | First-cycle vertical blank event |
| rst_busy_o | output | 1 | Soft reset in progress |

## Verification
The hardest situation to create from the ports is the shadow copy at the frame wrap. The bench has to show that new values stay invisible for a whole running frame. It must then show that they take effect exactly on the first pixel of the next frame. To do this, the bench starts from a known frame origin, loads a changed geometry and polarity with the update request low, and sweeps a full frame. It then raises the request at pixel 0 of the next frame and sweeps that frame against the old values. Finally it sweeps one more frame against the new ones. Every output is compared on every cycle against positions computed arithmetically from a cycle index.

// File: rtl/video_timing_gen.sv
module video_timing_gen #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         glb_en_i,
  input  logic         gen_en_i,
  input  logic         soft_rst_i,
  input  logic         upd_req_i,
  input  logic [W-1:0] cfg_htotal_i,
  input  logic [W-1:0] cfg_hactive_i,
  input  logic [W-1:0] cfg_vtotal_i,
  input  logic [W-1:0] cfg_vactive_i,
  input  logic [W-1:0] cfg_hs_beg_i,
  input  logic [W-1:0] cfg_hs_fin_i,
  input  logic [W-1:0] cfg_vs_beg_line_i,
  input  logic [W-1:0] cfg_vs_beg_cyc_i,
  input  logic [W-1:0] cfg_vs_fin_line_i,
  input  logic [W-1:0] cfg_vs_fin_cyc_i,
  input  logic [W-1:0] cfg_vb_beg_cyc_i,
  input  logic [W-1:0] cfg_vb_fin_cyc_i,
  input  logic [W-1:0] cfg_fs_line_i,
  input  logic [W-1:0] cfg_fs_cyc_i,
  input  logic [6:0]   cfg_pol_i,
  input  logic [1:0]   cfg_fmt_i,
  input  logic [1:0]   cfg_cpar_i,
  output logic         hsync_o,
  output logic         vsync_o,
  output logic         hblank_o,
  output logic         vblank_o,
  output logic         video_o,
  output logic         chroma_o,
  output logic         field_o,
  output logic         fsync_o,
  output logic         ev_video_o,
  output logic         ev_vblank_o,
  output logic         rst_busy_o
);
  localparam logic [1:0] FMT_420 = 2'd3;

  logic [W-1:0] w_htot, w_hact, w_vtot, w_vact, w_hsb, w_hsf;
  logic [W-1:0] w_vsbl, w_vsbc, w_vsfl, w_vsfc, w_vbb, w_vbf, w_fsl, w_fsc;
  logic [6:0]   w_pol;
  logic [1:0]   w_fmt, w_cpar;

  logic [W-1:0] hcnt, vcnt;
  logic         sr_q, vs_q, vb_q, av_q;
  logic         run, last_h, last_v, load;
  logic         hs_int, vs_int, vb_int, av_int, hb_int, ch_int, in_h;

  assign run    = (glb_en_i | gen_en_i) & ~sr_q;
  assign last_h = hcnt == w_htot - 1'b1;
  assign last_v = vcnt == w_vtot - 1'b1;
  assign load   = upd_req_i & (~run | (last_h & last_v));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_htot <= '0; w_hact <= '0; w_vtot <= '0; w_vact <= '0;
      w_hsb  <= '0; w_hsf  <= '0; w_vsbl <= '0; w_vsbc <= '0;
      w_vsfl <= '0; w_vsfc <= '0; w_vbb  <= '0; w_vbf  <= '0;
      w_fsl  <= '0; w_fsc  <= '0; w_pol  <= '0; w_fmt  <= '0;
      w_cpar <= '0;
    end else if (load) begin
      w_htot <= cfg_htotal_i;      w_hact <= cfg_hactive_i;
      w_vtot <= cfg_vtotal_i;      w_vact <= cfg_vactive_i;
      w_hsb  <= cfg_hs_beg_i;      w_hsf  <= cfg_hs_fin_i;
      w_vsbl <= cfg_vs_beg_line_i; w_vsbc <= cfg_vs_beg_cyc_i;
      w_vsfl <= cfg_vs_fin_line_i; w_vsfc <= cfg_vs_fin_cyc_i;
      w_vbb  <= cfg_vb_beg_cyc_i;  w_vbf  <= cfg_vb_fin_cyc_i;
      w_fsl  <= cfg_fs_line_i;     w_fsc  <= cfg_fs_cyc_i;
      w_pol  <= cfg_pol_i;         w_fmt  <= cfg_fmt_i;
      w_cpar <= cfg_cpar_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (last_h) begin
      hcnt <= '0;
      vcnt <= last_v ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= 1'b0;
      vs_q <= 1'b0;
      vb_q <= 1'b0;
      av_q <= 1'b0;
    end else begin
      sr_q <= soft_rst_i;
      vs_q <= vs_int;
      vb_q <= vb_int;
      av_q <= av_int;
    end
  end

  assign in_h   = hcnt < w_hact;
  assign hs_int = run & (hcnt >= w_hsb) & (hcnt < w_hsf);
  assign av_int = run & in_h & (vcnt < w_vact);
  assign hb_int = run & ~in_h;

  assign vs_int = run & ((vcnt == w_vsbl && hcnt == w_vsbc) |
                         (vs_q & ~(vcnt == w_vsfl && hcnt == w_vsfc)));
  assign vb_int = run & ((vcnt == w_vact && hcnt == w_vbb) |
                         (vb_q & ~(vcnt == '0 && hcnt == w_vbf)));

  assign ch_int = av_int & ((w_fmt != FMT_420) |
                  ((vcnt[0] == w_cpar[0]) & (~w_cpar[1] | ~hcnt[0])));

  assign hsync_o  = hs_int ~^ w_pol[0];
  assign vsync_o  = vs_int ~^ w_pol[1];
  assign hblank_o = hb_int ~^ w_pol[2];
  assign vblank_o = vb_int ~^ w_pol[3];
  assign video_o  = av_int ~^ w_pol[4];
  assign chroma_o = ch_int ~^ w_pol[5];
  assign field_o  = w_pol[6];

  assign fsync_o     = run & (vcnt == w_fsl) & (hcnt == w_fsc);
  assign ev_video_o  = av_int & ~av_q;
  assign ev_vblank_o = vb_int & ~vb_q;
  assign rst_busy_o  = sr_q;
endmodule

module video_timing_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       glb_en_i,
  input logic       gen_en_i,
  input logic       soft_rst_i,
  input logic       rst_busy_o,
  input logic       fsync_o,
  input logic       ev_video_o,
  input logic       ev_vblank_o,
  input logic       video_o,
  input logic       vblank_o,
  input logic [6:0] w_pol
);
  // R8
  ev_video_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_video_o |=> !ev_video_o);
  // R8
  ev_video_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_video_o |-> (video_o == w_pol[4]));
  // R8
  ev_vblank_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_vblank_o |-> (vblank_o == w_pol[3]));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i && !gen_en_i) |-> (!fsync_o && !ev_video_o && !ev_vblank_o));
  // R11
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> rst_busy_o);
  // R11
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_busy_o && !soft_rst_i) |=> !rst_busy_o);
endmodule

bind video_timing_gen video_timing_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .gen_en_i(gen_en_i),
  .soft_rst_i(soft_rst_i), .rst_busy_o(rst_busy_o), .fsync_o(fsync_o),
  .ev_video_o(ev_video_o), .ev_vblank_o(ev_vblank_o), .video_o(video_o),
  .vblank_o(vblank_o), .w_pol(w_pol)
);

// File: tb/tb_video_timing_gen.sv
module tb_video_timing_gen;
  localparam int W = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic glb = 0, gen = 0, srst = 0, upd = 0;
  logic [W-1:0] c_ht, c_ha, c_vt, c_va, c_hsb, c_hsf, c_vsbl, c_vsbc, c_vsfl, c_vsfc;
  logic [W-1:0] c_vbb, c_vbf, c_fsl, c_fsc;
  logic [6:0] c_pol;
  logic [1:0] c_fmt, c_cpar;
  logic hs, vs, hb, vb, av, ch, fid, fs, eav, evb, busy;

  video_timing_gen #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb), .gen_en_i(gen), .soft_rst_i(srst),
    .upd_req_i(upd), .cfg_htotal_i(c_ht), .cfg_hactive_i(c_ha), .cfg_vtotal_i(c_vt),
    .cfg_vactive_i(c_va), .cfg_hs_beg_i(c_hsb), .cfg_hs_fin_i(c_hsf),
    .cfg_vs_beg_line_i(c_vsbl), .cfg_vs_beg_cyc_i(c_vsbc), .cfg_vs_fin_line_i(c_vsfl),
    .cfg_vs_fin_cyc_i(c_vsfc), .cfg_vb_beg_cyc_i(c_vbb), .cfg_vb_fin_cyc_i(c_vbf),
    .cfg_fs_line_i(c_fsl), .cfg_fs_cyc_i(c_fsc), .cfg_pol_i(c_pol), .cfg_fmt_i(c_fmt),
    .cfg_cpar_i(c_cpar), .hsync_o(hs), .vsync_o(vs), .hblank_o(hb), .vblank_o(vb),
    .video_o(av), .chroma_o(ch), .field_o(fid), .fsync_o(fs), .ev_video_o(eav),
    .ev_vblank_o(evb), .rst_busy_o(busy));

  int checks = 0, fails = 0, t = 0;
  int e_ht, e_ha, e_vt, e_va, e_hsb, e_hsf, e_vsb, e_vsf, e_vbb, e_vbf, e_fs;
  logic [6:0] e_pol;
  logic [1:0] e_fmt, e_cpar;

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%b expected=%b", req, t, got, exp);
    end
  endtask

  task automatic set_a();
    c_ht = 10; c_ha = 6; c_vt = 6; c_va = 4; c_hsb = 7; c_hsf = 9;
    c_vsbl = 4; c_vsbc = 3; c_vsfl = 5; c_vsfc = 2; c_vbb = 6; c_vbf = 8;
    c_fsl = 2; c_fsc = 5; c_pol = 7'h7F; c_fmt = 0; c_cpar = 0;
  endtask

  task automatic take();
    e_ht = int'(c_ht); e_ha = int'(c_ha); e_vt = int'(c_vt); e_va = int'(c_va);
    e_hsb = int'(c_hsb); e_hsf = int'(c_hsf);
    e_vsb = int'(c_vsbl) * e_ht + int'(c_vsbc); e_vsf = int'(c_vsfl) * e_ht + int'(c_vsfc);
    e_vbb = e_va * e_ht + int'(c_vbb); e_vbf = int'(c_vbf);
    e_fs = int'(c_fsl) * e_ht + int'(c_fsc);
    e_pol = c_pol; e_fmt = c_fmt; e_cpar = c_cpar;
  endtask

  task automatic load_stopped();
    upd = 1; @(negedge clk); upd = 0; take();
  endtask

  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) begin
      int p, fr, h, v;
      logic ea, ec;
      #1;
      p = t % (e_ht * e_vt); fr = t / (e_ht * e_vt); h = p % e_ht; v = p / e_ht;
      ea = (h < e_ha) && (v < e_va);
      ec = ea && ((e_fmt != 2'd3) ||
            ((v % 2 == int'(e_cpar[0])) && (!e_cpar[1] || h % 2 == 0)));
      chk(hs,  ((h >= e_hsb) && (h < e_hsf)) ~^ e_pol[0], "R1 hsync");
      chk(vs,  ((p >= e_vsb) && (p < e_vsf)) ~^ e_pol[1], "R2 vsync");
      chk(hb,  (h >= e_ha) ~^ e_pol[2], "R4 hblank");
      chk(vb,  ((p >= e_vbb) || (fr > 0 && p < e_vbf)) ~^ e_pol[3], "R3 vblank");
      chk(av,  ea ~^ e_pol[4], "R4 video");
      chk(ch,  ec ~^ e_pol[5], "R6 chroma");
      chk(fid, e_pol[6], "R5 field");
      chk(fs,  p == e_fs, "R9 fsync");
      chk(eav, ea && h == 0, "R8 video event");
      chk(evb, p == e_vbb, "R8 vblank event");
      t++;
      @(negedge clk);
    end
  endtask

  task automatic idle_check(input string req);
    #1;
    chk(hs, ~e_pol[0], req); chk(vs, ~e_pol[1], req); chk(hb, ~e_pol[2], req);
    chk(vb, ~e_pol[3], req); chk(av, ~e_pol[4], req); chk(ch, ~e_pol[5], req);
    chk(fid, e_pol[6], req); chk(fs, 1'b0, req); chk(eav, 1'b0, req); chk(evb, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    set_a();
    e_pol = 7'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    e_ht = 1; e_vt = 1;
    idle_check("R12 reset");
    chk(busy, 1'b0, "R12 busy");

    load_stopped();
    glb = 1; t = 0;
    sweep(120);

    // R7 shadow values held until a requested frame wrap
    glb = 0; @(negedge clk);
    c_ha = 4; c_pol = 7'h7E; c_fsl = 1; c_fsc = 1;
    @(negedge clk);
    glb = 1; t = 0;
    sweep(60);
    upd = 1;
    sweep(60);
    upd = 0; take();
    sweep(60);

    // R10 stopped: inactive levels for a mixed polarity
    glb = 0; @(negedge clk);
    c_pol = 7'h2A; load_stopped();
    for (int k = 0; k < 5; k++) begin
      idle_check("R10 stopped");
      @(negedge clk);
    end

    // R6 formats and 4:2:0 parity modes
    for (int m = 0; m < 6; m++) begin
      set_a();
      c_fmt = (m < 4) ? 2'd3 : 2'(m - 3);
      c_cpar = 2'(m % 4);
      load_stopped();
      glb = 1; t = 0;
      sweep(60);
      glb = 0; @(negedge clk);
    end

    // R10 generator-only enable
    gen = 1; t = 0;
    sweep(60);

    // R11 soft reset mid-frame
    sweep(13);
    srst = 1; @(negedge clk); srst = 0;
    #1 chk(busy, 1'b1, "R11 busy set");
    chk(av, ~e_pol[4], "R11 inactive during reset");
    chk(fs, 1'b0, "R11 no fsync during reset");
    @(negedge clk);
    #1 chk(busy, 1'b0, "R11 busy cleared");
    t = 0;
    sweep(60);
    gen = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule